// File: doc/BRIEF.md
# Receive Packet Queue Status Tracker

This block keeps account of the packets sitting in a receive buffer and shows a 16-bit status word for the oldest one. The receive MAC drives it with three strobes: packet start, one per byte, and packet end. The end strobe carries a 4-bit error code. The host side reads bytes from the oldest packet one at a time, or drops that packet whole with a discard command. The byte storage is not built. It is modelled as an occupancy count checked against a capacity parameter.

At most `PKT_DEPTH` completed packets can wait in the queue. When a limit is reached, new packets are refused rather than overwritten, and a sticky diagnostic flag records the stall. A flag also records that the host read past the end of the oldest packet. That misuse pulses an adapter-failure event and stays flagged until a receive reset. The block also pulses an event when a packet completes and an early event part-way through reception.

Top module: `rx_pkt_tracker`

## Requirements
- R1: After reset, `stat_word` is 16'h8000, all four flags are 0 and no event pulses.
- R2: A packet end while receiving stores the packet. `ev_done` is high for exactly the one cycle after the end strobe. With the head packet complete, `stat_word` is {1'b0, code[3:0], len[10:0]}.
- R3: Error codes pass into bits 14..11 unchanged only when they are 4'b1000, 4'b1011, 4'b1100, 4'b1101, 4'b1001 or 4'b0010. Any other code is reported as 4'b0000.
- R4: `flg_busy` is 1 from an accepted start until the end strobe. While the queue is empty, `stat_word` is {1'b1, 4'b0000, bytes received so far}.
- R5: Packets leave in arrival order. A discard removes the head and shows the next packet's status.
- R6: A start while `PKT_DEPTH` packets are queued is refused and sets `flg_slot_full`. The byte and end strobes that follow are ignored. A discard clears the flag.
- R7: A start or byte arriving while the occupancy equals `BYTE_CAP` is refused and sets `flg_byte_full`. Any host read or discard that frees bytes clears the flag.
- R8: A host read with no queued packet, or one past the head's length, sets `flg_underrun` and pulses `ev_fail`. Discards do not clear the flag. Only a receive reset or reset does.
- R9: A discard with an empty queue has no effect.
- R10: `ev_early` pulses once, in the cycle after the byte that brings the in-progress count to `early_thr`. Values below 4 are treated as 4.
- R11: `rx_rst` empties the queue and clears every count, flag and event. The block then looks as it does after reset.
- R12: A discard frees the head packet's unread bytes. A host read frees one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_rst | input | 1 | Receive reset command |
| mac_sop | input | 1 | Packet start strobe from the MAC |
| mac_byte | input | 1 | One received byte |
| mac_eop | input | 1 | Packet end strobe |
| mac_code | input | 4 | Error code given with the end strobe |
| host_rd | input | 1 | Host reads one byte of the head packet |
| discard | input | 1 | Drop the head packet |
| early_thr | input | 11 | Early-event byte threshold |
| stat_word | output | 16 | Status of the head packet |
| flg_busy | output | 1 | A packet is being received |
| flg_byte_full | output | 1 | Byte store overrun |
| flg_slot_full | output | 1 | Packet queue overrun |
| flg_underrun | output | 1 | Host read past a packet's end |
| ev_done | output | 1 | Packet-complete pulse |
| ev_fail | output | 1 | Adapter-failure pulse |
| ev_early | output | 1 | Early-receive pulse |

## Verification
The bench uses a small byte capacity, so it can fill the store exactly to the limit and then one byte past it. A design with an off-by-one full test would flag one byte early or one byte late. The bench then discards a partly read packet and refills the store to its exact limit. This shows whether only the unread bytes were released: releasing the full length, or nothing, would move the overrun point. It also reads exactly one byte past a packet's end and then discards that packet. A design that raised the failure at the last valid byte, or let the discard clear the sticky flag, would be caught here. Early thresholds below and above the floor of 4, and undefined error codes, complete the set.

// File: rtl/rx_trk_pkg.sv
package rx_trk_pkg;
  localparam int RX_LEN_W  = 11;
  localparam int RX_CODE_W = 4;

  typedef struct packed {
    logic [RX_CODE_W-1:0] code;
    logic [RX_LEN_W-1:0]  len;
  } rx_ent_t;

  // Keep only the recognised error codes; anything else reads as clean.
  function automatic logic [RX_CODE_W-1:0] map_code(input logic [RX_CODE_W-1:0] c);
    case (c)
      4'b1000, 4'b1011, 4'b1100, 4'b1101, 4'b1001, 4'b0010: map_code = c;
      default: map_code = '0;
    endcase
  endfunction
endpackage

// File: rtl/rx_stat_queue.sv
module rx_stat_queue
  import rx_trk_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    push,
  input  rx_ent_t push_ent,
  input  logic    pop,
  output rx_ent_t head,
  output logic    full,
  output logic    empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rx_ent_t           mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;
  logic              wr_ok, rd_ok;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    nxt = (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
  assign rd_ok = pop & ~empty;
  assign wr_ok = push & (~full | rd_ok);
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= nxt(wp);
      if (rd_ok) rp <= nxt(rp);
      cnt <= cnt + CNT_W'(wr_ok) - CNT_W'(rd_ok);
    end
  end

  // R6
  q_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  // R5
  q_pop_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ok & ~wr_ok) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/rx_occ_ctr.sv
module rx_occ_ctr #(
  parameter int CAP   = 2048,
  parameter int OCC_W = $clog2(CAP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic [OCC_W-1:0] dec,
  output logic             full
);
  logic [OCC_W-1:0] occ_q;

  assign full = (occ_q == OCC_W'(CAP));

  always_ff @(posedge clk) begin
    if (rst) occ_q <= '0;
    else     occ_q <= occ_q + OCC_W'(inc) - dec;
  end

  // R7
  occ_cap_chk: assert property (@(posedge clk) disable iff (rst)
    occ_q <= OCC_W'(CAP));

  // R12
  occ_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (dec != '0) |-> (dec <= occ_q));
endmodule

// File: rtl/rx_pkt_tracker.sv
module rx_pkt_tracker
  import rx_trk_pkg::*;
#(
  parameter int PKT_DEPTH = 8,
  parameter int BYTE_CAP  = 2048
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_rst,
  input  logic                 mac_sop,
  input  logic                 mac_byte,
  input  logic                 mac_eop,
  input  logic [RX_CODE_W-1:0] mac_code,
  input  logic                 host_rd,
  input  logic                 discard,
  input  logic [RX_LEN_W-1:0]  early_thr,
  output logic [15:0]          stat_word,
  output logic                 flg_busy,
  output logic                 flg_byte_full,
  output logic                 flg_slot_full,
  output logic                 flg_underrun,
  output logic                 ev_done,
  output logic                 ev_fail,
  output logic                 ev_early
);
  localparam int OCC_W = $clog2(BYTE_CAP + 1);
  localparam int LW    = RX_LEN_W;

  logic          clr;
  logic [LW-1:0] cur_len, head_rd, len_nxt, eff_thr;
  rx_ent_t       head, push_ent;
  logic          q_full, q_empty, occ_full;
  logic          byte_ok, byte_ref, sop_try, sop_ok, sop_slot_ref, sop_byte_ref;
  logic          eop_ok, len_inc, pop, rd_ok, rd_bad, early_hit;
  logic [OCC_W-1:0] dec_amt;

  assign clr          = rst | rx_rst;
  assign byte_ok      = flg_busy & mac_byte & ~occ_full;
  assign byte_ref     = flg_busy & mac_byte & occ_full;
  assign sop_try      = mac_sop & ~flg_busy;
  assign sop_slot_ref = sop_try & q_full;
  assign sop_byte_ref = sop_try & ~q_full & occ_full;
  assign sop_ok       = sop_try & ~q_full & ~occ_full;
  assign eop_ok       = flg_busy & mac_eop;
  assign len_inc      = byte_ok & (cur_len != '1);
  assign len_nxt      = cur_len + LW'(len_inc);
  assign pop          = discard & ~q_empty;
  assign rd_ok        = host_rd & ~discard & ~q_empty & (head_rd < head.len);
  assign rd_bad       = host_rd & ~discard & ~rd_ok;
  assign dec_amt      = pop   ? OCC_W'(head.len - head_rd) :
                        rd_ok ? OCC_W'(1) : '0;
  assign eff_thr      = (early_thr < LW'(4)) ? LW'(4) : early_thr;
  assign early_hit    = byte_ok & (({1'b0, cur_len} + (LW+1)'(1)) == {1'b0, eff_thr});
  assign push_ent     = '{code: map_code(mac_code), len: len_nxt};

  assign stat_word = q_empty ? {1'b1, 4'b0000, cur_len}
                             : {1'b0, head.code, head.len};

  rx_stat_queue #(.DEPTH(PKT_DEPTH)) u_queue (
    .clk      (clk),
    .rst      (clr),
    .push     (eop_ok),
    .push_ent (push_ent),
    .pop      (pop),
    .head     (head),
    .full     (q_full),
    .empty    (q_empty)
  );

  rx_occ_ctr #(.CAP(BYTE_CAP), .OCC_W(OCC_W)) u_occ (
    .clk  (clk),
    .rst  (clr),
    .inc  (byte_ok),
    .dec  (dec_amt),
    .full (occ_full)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      flg_busy      <= 1'b0;
      cur_len       <= '0;
      head_rd       <= '0;
      flg_byte_full <= 1'b0;
      flg_slot_full <= 1'b0;
      flg_underrun  <= 1'b0;
      ev_done       <= 1'b0;
      ev_fail       <= 1'b0;
      ev_early      <= 1'b0;
    end else begin
      if (sop_ok)      flg_busy <= 1'b1;
      else if (eop_ok) flg_busy <= 1'b0;

      if (sop_ok | eop_ok) cur_len <= '0;
      else                 cur_len <= len_nxt;

      if (pop)        head_rd <= '0;
      else if (rd_ok) head_rd <= head_rd + LW'(1);

      if (pop)               flg_slot_full <= 1'b0;
      else if (sop_slot_ref) flg_slot_full <= 1'b1;

      if (dec_amt != '0)                flg_byte_full <= 1'b0;
      else if (sop_byte_ref | byte_ref) flg_byte_full <= 1'b1;

      if (rd_bad) flg_underrun <= 1'b1;

      ev_done  <= eop_ok;
      ev_fail  <= rd_bad;
      ev_early <= early_hit;
    end
  end

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flg_underrun & ~rx_rst) |=> flg_underrun);

  // R8
  fail_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ev_fail |-> flg_underrun);

  // R2
  done_after_eop_chk: assert property (@(posedge clk) disable iff (rst)
    ev_done |-> $past(mac_eop & flg_busy));

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flg_busy) |-> $past(mac_sop));

  // R6
  slot_block_chk: assert property (@(posedge clk) disable iff (rst)
    (q_full & mac_sop & ~flg_busy & ~rx_rst) |=> ~flg_busy);
endmodule

// File: tb/rx_pkt_tracker_test.sv
module rx_pkt_tracker_test;
  logic clk = 1'b0;
  logic rst = 1'b1, rx_rst = 1'b0;
  logic mac_sop = 1'b0, mac_byte = 1'b0, mac_eop = 1'b0;
  logic [3:0] mac_code = 4'b0;
  logic host_rd = 1'b0, discard = 1'b0;
  logic [10:0] early_thr = 11'd64;
  logic [15:0] stat_word;
  logic flg_busy, flg_byte_full, flg_slot_full, flg_underrun;
  logic ev_done, ev_fail, ev_early;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rx_pkt_tracker #(.PKT_DEPTH(8), .BYTE_CAP(32)) uut (
    .clk(clk), .rst(rst), .rx_rst(rx_rst), .mac_sop(mac_sop), .mac_byte(mac_byte),
    .mac_eop(mac_eop), .mac_code(mac_code), .host_rd(host_rd), .discard(discard),
    .early_thr(early_thr), .stat_word(stat_word), .flg_busy(flg_busy),
    .flg_byte_full(flg_byte_full), .flg_slot_full(flg_slot_full),
    .flg_underrun(flg_underrun), .ev_done(ev_done), .ev_fail(ev_fail),
    .ev_early(ev_early)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic b, input logic e,
                     input logic r, input logic d, input logic rr);
    mac_sop = s; mac_byte = b; mac_eop = e; host_rd = r; discard = d; rx_rst = rr;
    @(posedge clk); #2;
    mac_sop = 0; mac_byte = 0; mac_eop = 0; host_rd = 0; discard = 0; rx_rst = 0;
  endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 0, 0);
  endtask

  task automatic send_pkt(input int n, input logic [3:0] code);
    cyc(1, 0, 0, 0, 0, 0);
    bytes(n);
    mac_code = code;
    cyc(0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_reset;
    rst = 1; @(posedge clk); @(posedge clk); #2; rst = 0;
    chk("R1 status", stat_word, 16'h8000);
    chk("R1 flags", {flg_busy, flg_byte_full, flg_slot_full, flg_underrun}, 0);
    chk("R1 events", {ev_done, ev_fail, ev_early}, 0);
  endtask

  task automatic t_basic;
    cyc(1, 0, 0, 0, 0, 0);
    bytes(3);
    chk("R4 busy", flg_busy, 1);
    chk("R4 partial status", stat_word, 16'h8003);
    bytes(2);
    mac_code = 4'b0000;
    cyc(0, 0, 1, 0, 0, 0);
    chk("R2 done pulse", ev_done, 1);
    chk("R4 busy end", flg_busy, 0);
    chk("R2 status", stat_word, 16'h0005);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R2 single pulse", ev_done, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 0, 0);
    chk("R8 no fail in range", {ev_fail, flg_underrun}, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R8 fail pulse", ev_fail, 1);
    chk("R8 underrun set", flg_underrun, 1);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R8 sticky after discard", flg_underrun, 1);
    chk("R8 fail single", ev_fail, 0);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R11 underrun cleared", flg_underrun, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R8 read empty fails", {ev_fail, flg_underrun}, 2'b11);
    cyc(0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_codes;
    logic [3:0]  codes [8] = '{4'b1000, 4'b1011, 4'b1100, 4'b1101,
                               4'b1001, 4'b0010, 4'b0101, 4'b1111};
    logic [15:0] exps  [8] = '{16'h4001, 16'h5801, 16'h6001, 16'h6801,
                               16'h4801, 16'h1001, 16'h0001, 16'h0001};
    for (int i = 0; i < 8; i++) begin
      send_pkt(1, codes[i]);
      chk("R3 code mapping", stat_word, exps[i]);
      cyc(0, 0, 0, 0, 1, 0);
    end
  endtask

  task automatic t_order;
    send_pkt(1, 4'b0000);
    send_pkt(2, 4'b1101);
    send_pkt(3, 4'b0000);
    chk("R5 head first", stat_word, 16'h0001);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R5 head second", stat_word, 16'h6802);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R5 head third", stat_word, 16'h0003);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R5 drained", stat_word, 16'h8000);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R9 empty discard status", stat_word, 16'h8000);
    chk("R9 empty discard no fail", {ev_fail, flg_underrun, flg_slot_full}, 0);
    cyc(0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_slots;
    for (int i = 0; i < 8; i++) send_pkt(2, 4'b0000);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R6 slot flag", flg_slot_full, 1);
    chk("R6 refused start", flg_busy, 0);
    bytes(2);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R6 end ignored", ev_done, 0);
    chk("R6 head unchanged", stat_word, 16'h0002);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R6 flag cleared by discard", flg_slot_full, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R6 start accepted again", flg_busy, 1);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R11 busy cleared", flg_busy, 0);
  endtask

  task automatic t_bytes;
    send_pkt(20, 4'b0000);
    cyc(1, 0, 0, 0, 0, 0);
    bytes(12);
    chk("R7 exact fill no flag", flg_byte_full, 0);
    bytes(1);
    chk("R7 byte overrun", flg_byte_full, 1);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R7 head A", stat_word, 16'h0014);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R7 start refused", flg_busy, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R7 read clears flag", flg_byte_full, 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R5 head B", stat_word, 16'h000c);
    cyc(1, 0, 0, 0, 0, 0);
    bytes(20);
    chk("R12 released 19 bytes", flg_byte_full, 0);
    bytes(1);
    chk("R12 full at new limit", flg_byte_full, 1);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R11 status", stat_word, 16'h8000);
    chk("R11 flags", {flg_busy, flg_byte_full, flg_slot_full, flg_underrun}, 0);
  endtask

  task automatic t_early;
    early_thr = 11'd2;
    cyc(1, 0, 0, 0, 0, 0);
    bytes(3);
    chk("R10 floor not yet", ev_early, 0);
    bytes(1);
    chk("R10 floor hit", ev_early, 1);
    bytes(1);
    chk("R10 single pulse", ev_early, 0);
    cyc(0, 0, 0, 0, 0, 1);
    early_thr = 11'd10;
    cyc(1, 0, 0, 0, 0, 0);
    bytes(9);
    chk("R10 before thr", ev_early, 0);
    bytes(1);
    chk("R10 at thr", ev_early, 1);
    cyc(0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_codes();
    t_order();
    t_slots();
    t_bytes();
    t_early();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule